// File: doc/BRIEF.md
# SPI Controller with Per-Frame Command FIFO

This block drives a four-wire SPI bus as the controller. Software, or a neighbouring block, pushes command words into a small transmit queue. Each word holds one data byte and the control for that frame: which chip-select lines go low, whether the selects are released once the frame ends, whether the received bits are discarded, and how many bits the frame has. The engine takes words off the queue one at a time and shifts them out most significant bit first. It samples the incoming line on the edge that the clock-phase setting picks, and places each received byte in a receive queue.

Global settings are held on plain configuration inputs: an enable, a controller-mode select, clock polarity, clock phase and a 16-bit divider. Status outputs report the queue levels and two sticky error flags. Because chip-select control travels with every frame, a multi-byte transaction is written as a run of words with the release flag clear. Only the last word of the run sets it.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: Transmit word bits [11:8] drive `cs_n[3:0]` for the frame started from that word, so a 0 bit pulls that select low. All selects are high after reset.
- R2: Transmit word bit 12 (release) set returns all of `cs_n` to 4'hF once the frame ends. With bit 12 clear, `cs_n` keeps the frame's value until the next frame or until the engine is disabled.
- R3: Transmit word bit 13 (discard) set keeps the frame's received byte out of the receive queue.
- R4: Transmit word bits [16:14] hold the frame length minus one. A frame shifts out data bits `len` down to 0, most significant first, on `copi`. The bits received on `cipo` land in the low `len+1` bits of the received byte, and the upper bits are 0.
- R5: Each SCK half period lasts `cfg_div + 1` clock cycles (value 0 means divide by 1, up to 65536).
- R6: With `cfg_cpha`=0, `cipo` is sampled on the leading (first) SCK edge and `copi` changes on the trailing edge. With `cfg_cpha`=1, `copi` changes on the leading edge and `cipo` is sampled on the trailing edge. `cfg_cpol` selects the level SCK rests at.
- R7: Frames run only while both `cfg_enable` and `cfg_controller` are 1. When either is 0 no SCK edge occurs, queued words stay queued, `cs_n` is 4'hF and SCK rests at `cfg_cpol`.
- R8: `st_tx_empty`, `st_tx_not_full` and `st_rx_not_empty` track the two queue levels.
- R9: `st_tx_err` sets when a push arrives while the transmit queue is full, and the word is dropped. Both error flags stay set until a 1 on `err_clr[0]` (transmit) or `err_clr[1]` (receive) clears them.
- R10: `st_rx_err` sets when a frame with bit 13 clear completes while the receive queue is full. The byte is dropped and the queue contents are unchanged.
- R11: A pulse on `tx_flush` or `rx_flush` empties that queue.
- R12: A select driven low from the all-high state goes low one half period before the first SCK edge. With bit 12 set it returns high one half period after the last edge.
- R13: Each queue holds 4 entries and returns them in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_controller | input | 1 | Controller-mode select |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | 16 | Half-period divide ratio minus one |
| tx_push | input | 1 | Push `tx_word` into the transmit queue |
| tx_word | input | 17 | {len[2:0], discard, release, cs_n[3:0], data[7:0]} |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| err_clr | input | 2 | Write-1 clear: bit 0 transmit error, bit 1 receive error |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_not_full | output | 1 | Transmit queue has space |
| st_rx_not_empty | output | 1 | Receive queue holds data |
| st_tx_err | output | 1 | Sticky transmit overflow |
| st_rx_err | output | 1 | Sticky receive overflow |
| sck | output | 1 | Serial clock |
| copi | output | 1 | Controller data out |
| cipo | input | 1 | Controller data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench runs every polarity and phase pairing against several divider values, frame lengths and select patterns, with `cipo` looped back from `copi` either straight or inverted. If a design sampled on the wrong edge, the bit sequence rebuilt from the pins would shift or lose its first bit. If it miscounted the length field, it would shift the wrong number of bits or leave stray high bits in the received byte. The bench measures setup, half period and release in cycles, so an off-by-one divider or a select that moves together with the first edge shows up as a count one cycle off. Back-to-back frames with the release flag clear, receive overflow with a full queue, transmit overflow and flushes each target a design that releases the select too early, overwrites queued data, or loses the sticky flags.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_CS = 4;
    localparam int LEN_W  = $clog2(BYTE_W);
    localparam int DIV_W  = 16;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              rx_ign;
        logic              eot;
        logic [NUM_CS-1:0] cs_n;
        logic [BYTE_W-1:0] data;
    } tx_word_t;

    localparam int TXW_W = $bits(tx_word_t);

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_HOLD  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW:0]                 wptr;
        logic [AW:0]                 rptr;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [AW:0] level;
    logic        do_push, do_pop;

    always_comb begin
        d       = q;
        level   = q.wptr - q.rptr;
        full    = (level == FULL_CNT);
        empty   = (q.wptr == q.rptr);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = q.mem[q.rptr[AW-1:0]];
        if (flush) begin
            d.wptr = '0;
            d.rptr = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wptr[AW-1:0]] = din;
                d.wptr = q.wptr + 1'b1;
            end
            if (do_pop) begin
                d.rptr = q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R13: a push into a full queue leaves the head entry and the full state alone
    assert_full_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && $stable(dout)));

    // R13: occupancy never exceeds the configured depth
    assert_level_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wptr - q.rptr) <= FULL_CNT);
endmodule

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_regs_t;

    tick_regs_t q, d;

    always_comb begin
        d    = q;
        tick = run && (q.cnt >= div);
        if (!run || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R5: with a ratio above one, two ticks never fall on adjacent cycles
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              word_avail,
    input  tx_word_t          word,
    output logic              word_take,
    input  logic              cipo,
    output logic              sck,
    output logic              copi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        eng_state_e        state;
        tx_word_t          word;
        logic [LEN_W-1:0]  idx;
        logic [BYTE_W-1:0] rx;
        logic              sck;
        logic              copi;
        logic [NUM_CS-1:0] cs_n;
    } eng_regs_t;

    eng_regs_t        q, d;
    logic             leading;
    logic [LEN_W-1:0] idx_m1;

    always_comb begin
        d         = q;
        word_take = 1'b0;
        rx_push   = 1'b0;
        leading   = (q.sck == cpol);
        idx_m1    = q.idx - 1'b1;
        if (!run) begin
            d.state = ENG_IDLE;
            d.sck   = cpol;
            d.cs_n  = '1;
        end else begin
            if (q.state == ENG_IDLE) begin
                d.sck = cpol;
            end
            if (tick) begin
                unique case (q.state)
                    ENG_IDLE: begin
                        if (word_avail) begin
                            word_take = 1'b1;
                            d.word    = word;
                            d.idx     = word.len;
                            d.copi    = word.data[word.len];
                            d.rx      = '0;
                            d.cs_n    = word.cs_n;
                            d.state   = ENG_SHIFT;
                        end
                    end
                    ENG_SHIFT: begin
                        d.sck = ~q.sck;
                        if (leading) begin
                            if (!cpha) begin
                                d.rx = {q.rx[BYTE_W-2:0], cipo};
                            end else begin
                                d.copi = q.word.data[q.idx];
                            end
                        end else begin
                            if (cpha) begin
                                d.rx = {q.rx[BYTE_W-2:0], cipo};
                            end
                            if (q.idx == '0) begin
                                d.state = ENG_HOLD;
                            end else begin
                                d.idx = idx_m1;
                                if (!cpha) begin
                                    d.copi = q.word.data[idx_m1];
                                end
                            end
                        end
                    end
                    ENG_HOLD: begin
                        rx_push = !q.word.rx_ign;
                        if (q.word.eot) begin
                            d.cs_n = '1;
                        end
                        d.state = ENG_IDLE;
                    end
                    default: d.state = ENG_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ENG_IDLE;
            q.cs_n  <= '1;
        end else begin
            q <= d;
        end
    end

    assign sck     = q.sck;
    assign copi    = q.copi;
    assign cs_n    = q.cs_n;
    assign rx_byte = q.rx;

    // R1: the selects do not move while bits are being shifted
    assert_cs_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ENG_SHIFT && run) |=> $stable(cs_n));

    // R7: a stopped engine rests SCK at the polarity level and releases all selects
    assert_sck_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck == $past(cpol) && cs_n == '1));

    // R4: the bit index stays within the frame length
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ENG_SHIFT) |-> (q.idx <= q.word.len));
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_controller,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_push,
    input  logic [TXW_W-1:0]  tx_word,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic [1:0]        err_clr,
    output logic              st_tx_empty,
    output logic              st_tx_not_full,
    output logic              st_rx_not_empty,
    output logic              st_tx_err,
    output logic              st_rx_err,
    output logic              sck,
    output logic              copi,
    input  logic              cipo,
    output logic [NUM_CS-1:0] cs_n
);
    typedef struct packed {
        logic tx_err;
        logic rx_err;
    } err_regs_t;

    err_regs_t         q, d;
    logic              run, tick;
    logic [TXW_W-1:0]  tx_dout;
    tx_word_t          tx_head;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              eng_take, eng_rx_push, tx_avail;
    logic [BYTE_W-1:0] eng_rx_byte;
    logic              tx_drop, rx_drop;

    assign run      = cfg_enable && cfg_controller;
    assign tx_head  = tx_word_t'(tx_dout);
    assign tx_avail = !tx_empty && !tx_flush;

    spi_cmd_fifo #(.WIDTH(TXW_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_word),
        .pop(eng_take), .flush(tx_flush), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty)
    );

    spi_cmd_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(eng_rx_push), .din(eng_rx_byte),
        .pop(rx_pop), .flush(rx_flush), .dout(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    spi_sck_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
    );

    spi_frame_engine u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .cpol(cfg_cpol), .cpha(cfg_cpha),
        .word_avail(tx_avail), .word(tx_head), .word_take(eng_take),
        .cipo(cipo), .sck(sck), .copi(copi), .cs_n(cs_n),
        .rx_push(eng_rx_push), .rx_byte(eng_rx_byte)
    );

    always_comb begin
        d        = q;
        tx_drop  = tx_push && tx_full && !tx_flush;
        rx_drop  = eng_rx_push && rx_full && !rx_flush;
        d.tx_err = (q.tx_err && !err_clr[0]) || tx_drop;
        d.rx_err = (q.rx_err && !err_clr[1]) || rx_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign st_tx_empty     = tx_empty;
    assign st_tx_not_full  = !tx_full;
    assign st_rx_not_empty = !rx_empty;
    assign st_tx_err       = q.tx_err;
    assign st_rx_err       = q.rx_err;

    // R9: an error flag stays up until its clear bit is written
    assert_tx_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_tx_err && !err_clr[0]) |=> st_tx_err);
    assert_rx_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rx_err && !err_clr[1]) |=> st_rx_err);

    // R10: a completed frame meeting a full receive queue raises the flag and the queue stays full
    assert_rx_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_pop && !rx_flush) |=> (st_rx_err && rx_full));

    // R11: a transmit flush leaves the queue empty on the next cycle
    assert_tx_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> st_tx_empty);
endmodule

// File: tb/spi_cmd_ctrl_tb.sv
module spi_cmd_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_controller = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [15:0] cfg_div = '0;
    logic        tx_push = 1'b0;
    logic [16:0] tx_word = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        tx_flush = 1'b0, rx_flush = 1'b0;
    logic [1:0]  err_clr = '0;
    logic        st_tx_empty, st_tx_not_full, st_rx_not_empty, st_tx_err, st_rx_err;
    logic        sck, copi, cipo;
    logic [3:0]  cs_n;
    logic        inv = 1'b0;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign cipo = copi ^ inv;

    spi_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_controller(cfg_controller),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
        .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop), .rx_data(rx_data),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .err_clr(err_clr),
        .st_tx_empty(st_tx_empty), .st_tx_not_full(st_tx_not_full),
        .st_rx_not_empty(st_rx_not_empty), .st_tx_err(st_tx_err), .st_rx_err(st_rx_err),
        .sck(sck), .copi(copi), .cipo(cipo), .cs_n(cs_n)
    );

    // pin monitor
    bit         mon_on = 0, cs_fell = 0;
    int         nbits, edges, last_edge_cyc, gap_bad, setup_cyc, fall_cyc, rel_gap, exp_half;
    logic [7:0] cap;
    logic [3:0] cs_seen, cs_prev = 4'hF;
    logic       sck_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (cs_prev == 4'hF && cs_n != 4'hF) begin
                cs_fell  = 1;
                fall_cyc = cyc;
            end
            if (sck !== sck_prev) begin
                if (edges == 0) begin
                    if (cs_fell) setup_cyc = cyc - fall_cyc;
                end else if (cyc - last_edge_cyc != exp_half) begin
                    gap_bad++;
                end
                edges++;
                last_edge_cyc = cyc;
                if ((sck != cfg_cpol) != cfg_cpha) begin
                    cap     = {cap[6:0], copi};
                    nbits++;
                    cs_seen = cs_n;
                end
            end
            if (cs_prev != 4'hF && cs_n == 4'hF) rel_gap = cyc - last_edge_cyc;
        end
        sck_prev = sck;
        cs_prev  = cs_n;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_word(input logic [2:0] len, input logic ign, input logic eot,
                             input logic [3:0] cs, input logic [7:0] data);
        tx_word = {len, ign, eot, cs, data};
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pulse_pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic mon_reset();
        nbits = 0; cap = '0; edges = 0; gap_bad = 0; setup_cyc = -1;
        cs_fell = 0; rel_gap = -1; cs_seen = 4'h0; exp_half = int'(cfg_div) + 1;
        mon_on = 1;
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic [15:0] div);
        cfg_enable = 1'b0;
        tick_n(2);
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = div;
        tick_n(2);
        cfg_enable = 1'b1;
        tick_n(2);
    endtask

    task automatic run_frame(input logic [7:0] data, input logic [3:0] cs, input logic eot,
                             input logic ign, input logic [2:0] len);
        int half;
        logic [7:0] mask, exp_rx;
        half   = int'(cfg_div) + 1;
        mask   = 8'((9'd1 << (int'(len) + 1)) - 9'd1);
        exp_rx = (data ^ {8{inv}}) & mask;
        mon_reset();
        push_word(len, ign, eot, cs, data);
        tick_n((2 * int'(len) + 6) * half + 4);
        mon_on = 0;
        chk("R4", "bit count", nbits, int'(len) + 1);
        chk("R6", "copi bits at sample edges", cap & mask, data & mask);
        chk("R5", "half-period mismatches", gap_bad, 0);
        chk("R1", "cs_n during shift", cs_seen, cs);
        chk("R2", "cs_n after frame", cs_n, eot ? 4'hF : cs);
        chk("R7", "sck rest level", sck, cfg_cpol);
        chk("R8", "tx empty after frame", st_tx_empty, 1);
        if (cs_fell) chk("R12", "select setup cycles", setup_cyc, half);
        if (eot) chk("R12", "select release cycles", rel_gap, half);
        if (ign) begin
            chk("R3", "discarded frame left rx queue empty", st_rx_not_empty, 0);
        end else begin
            chk("R8", "rx not empty", st_rx_not_empty, 1);
            chk("R4", "received byte", rx_data, exp_rx);
            pulse_pop();
        end
    endtask

    initial begin : watchdog
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        tick_n(3);
        rst_n = 1'b1;
        tick_n(2);
        // reset state
        chk("R1", "cs_n after reset", cs_n, 4'hF);
        chk("R7", "sck after reset", sck, 0);
        chk("R8", "tx empty after reset", st_tx_empty, 1);
        chk("R8", "tx not full after reset", st_tx_not_full, 1);
        chk("R8", "rx not empty after reset", st_rx_not_empty, 0);
        chk("R9", "errors after reset", {st_tx_err, st_rx_err}, 0);
        cfg_controller = 1'b1;

        // mode, divider, length and pattern sweep
        for (int p = 0; p < 2; p++) begin
            for (int h = 0; h < 2; h++) begin
                for (int di = 0; di < 3; di++) begin
                    set_cfg(p[0], h[0], 16'((1 << di) - 1));
                    for (int k = 0; k < 4; k++) begin
                        logic [2:0] ln;
                        ln  = (k == 0) ? 3'd7 : (k == 1) ? 3'd3 : (k == 2) ? 3'd0 : 3'd5;
                        inv = k[0];
                        run_frame(8'h5A ^ 8'(k * 37 + di * 11 + p * 3 + h), ~(4'b1 << k),
                                  1'b1, (k == 2), ln);
                    end
                end
            end
        end
        inv = 1'b0;

        // held select across frames
        set_cfg(1'b1, 1'b0, 16'd1);
        run_frame(8'hC3, 4'b1011, 1'b0, 1'b0, 3'd7);
        run_frame(8'h96, 4'b1011, 1'b0, 1'b1, 3'd7);
        run_frame(8'h5E, 4'b1011, 1'b1, 1'b0, 3'd7);

        // stopped engine, transmit overflow, flush
        set_cfg(1'b0, 1'b0, 16'd0);
        cfg_enable = 1'b0;
        tick_n(2);
        mon_reset();
        for (int i = 0; i < 4; i++) begin
            push_word(3'd7, 1'b0, 1'b1, 4'hE, 8'(i));
            if (i == 2) chk("R13", "room after three pushes", st_tx_not_full, 1);
        end
        chk("R13", "full after four pushes", st_tx_not_full, 0);
        chk("R8", "tx not empty while stopped", st_tx_empty, 0);
        chk("R9", "no tx error before overflow", st_tx_err, 0);
        push_word(3'd7, 1'b0, 1'b1, 4'hE, 8'hFF);
        chk("R9", "tx error on overflow push", st_tx_err, 1);
        tick_n(40);
        chk("R9", "tx error sticky", st_tx_err, 1);
        chk("R7", "no sck edge while disabled", edges, 0);
        chk("R7", "selects high while disabled", cs_n, 4'hF);
        err_clr = 2'b01; @(negedge clk); err_clr = 2'b00;
        chk("R9", "tx error cleared", st_tx_err, 0);
        cfg_controller = 1'b0;
        cfg_enable = 1'b1;
        tick_n(40);
        chk("R7", "no sck edge outside controller mode", edges, 0);
        chk("R7", "queue kept outside controller mode", st_tx_not_full, 0);
        mon_on = 0;
        tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
        chk("R11", "tx empty after flush", st_tx_empty, 1);
        chk("R11", "tx room after flush", st_tx_not_full, 1);
        cfg_controller = 1'b1;
        tick_n(20);
        chk("R11", "flushed words never sent", cs_n, 4'hF);

        // receive overflow and ordering
        for (int i = 0; i < 5; i++) begin
            push_word(3'd7, 1'b0, 1'b1, 4'hE, 8'((i + 1) * 17));
            tick_n(30);
            if (i == 3) chk("R10", "no rx error with four held", st_rx_err, 0);
        end
        chk("R10", "rx error on fifth frame", st_rx_err, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R13", "rx order", rx_data, 8'((i + 1) * 17));
            pulse_pop();
        end
        chk("R10", "dropped byte not stored", st_rx_not_empty, 0);
        chk("R9", "rx error sticky", st_rx_err, 1);
        err_clr = 2'b10; @(negedge clk); err_clr = 2'b00;
        chk("R9", "rx error cleared", st_rx_err, 0);

        // receive flush
        push_word(3'd7, 1'b0, 1'b1, 4'hD, 8'h21);
        tick_n(30);
        push_word(3'd7, 1'b0, 1'b1, 4'hD, 8'h42);
        tick_n(30);
        chk("R8", "rx holds data before flush", st_rx_not_empty, 1);
        rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
        chk("R11", "rx empty after flush", st_rx_not_empty, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule